// File: doc/BRIEF.md
# Odd-Even Serial Block Access Port

This block is the access logic of one block-organized memory die. Storage is a small register array of 32 blocks, each 64 bits wide. Bit k of a block holds one bit position of word k, so a whole block is one bit-slice through 64 words. Access always covers a whole block.

Two half-length shift registers sit between the array and the single serial pin. The even register is wired in parallel to block positions 0, 2, 4 and so on. The odd register is wired to positions 1, 3, 5 and so on. A multiplexer alternates between the two registers on the pin. Each register therefore moves once per two pin slots, and the pin carries data at twice the rate of either register.

A one-cycle select strobe captures a block number and a direction. On the cycle after the strobe, the addressed block is loaded into both registers.

- **Read:** the block then streams out on the pin, word 0 first.
- **Write:** the pin input is collected in word order instead, steered alternately into the even and odd registers, and then committed to the array in one cycle.

Top module: `oe_block_port`

## Requirements
- R1: After reset, `busy_o`, `valid_o`, `take_o` and `sout_o` are 0, and every block of the array reads back as all zeros.
- R2: A strobe (`sel_i` = 1 while `busy_o` = 0) captures `addr_i` and `wr_i` and sets `busy_o` from the next cycle. The block is loaded on the cycle after the strobe. The first pin slot (`valid_o` or `take_o` high) follows after the next edge, two edges after the strobe.
- R3: A read (`wr_i` = 0 at the strobe) drives `valid_o` high for exactly 64 consecutive cycles. In slot s, `sout_o` carries bit s of the addressed block, for s = 0 to 63.
- R4: Slots alternate between the even and odd register: even slots come from the even register and odd slots from the odd register. A block holding 1 in every even position and 0 in every odd position therefore streams 1,0,1,0,...
- R5: A write (`wr_i` = 1 at the strobe) drives `take_o` high for exactly 64 consecutive cycles. The value on `sin_i` at the edge ending slot s becomes bit s of the block.
- R6: The cycle after the last write slot commits the collected 64 bits to the addressed block. No other block changes.
- R7: A strobe while `busy_o` = 1 is ignored: the ongoing stream, its length and the array are not affected.
- R8: `busy_o` falls right after the last read slot, 65 cycles after the strobe. For a write it falls right after the commit cycle, 66 cycles after the strobe. A new strobe is accepted on the first cycle `busy_o` is low.
- R9: `sout_o` is 0 whenever `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one pin slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Block-select strobe |
| wr_i | input | 1 | Direction at the strobe: 1 write, 0 read |
| addr_i | input | 5 | Block number captured at the strobe |
| sin_i | input | 1 | Serial write data, sampled while `take_o` is high |
| sout_o | output | 1 | Serial read data |
| valid_o | output | 1 | High during a read slot |
| take_o | output | 1 | High during a write slot |
| busy_o | output | 1 | An access is in progress |

## Verification
The bench writes all 32 blocks with distinct arithmetic patterns, including a strict even/odd alternation, and then reads every block back. It also reads a block before any write, which confirms reset contents.

The pattern sweep catches three kinds of fault:
- A swapped multiplexer select or a register that shifts every slot would scramble word order.
- A misplaced commit would corrupt a neighbouring block.
- A load one cycle late would shift the whole stream by one bit.

A spurious strobe is injected in mid-read. A design that honoured it would break off the stream or overwrite the array.

Busy length is timed exactly for both directions. An off-by-one slot counter would show up as one bit too many or too few.

// File: rtl/oe_block_port.sv
`timescale 1ns/1ps
module oe_block_port #(
  parameter int NBLK = 32,
  parameter int BITS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_i,
  input  logic                     wr_i,
  input  logic [$clog2(NBLK)-1:0]  addr_i,
  input  logic                     sin_i,
  output logic                     sout_o,
  output logic                     valid_o,
  output logic                     take_o,
  output logic                     busy_o
);
  localparam int HALF = BITS / 2;
  localparam int AW   = $clog2(NBLK);
  localparam int SW   = $clog2(BITS);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_COMMIT} st_t;

  st_t             st;
  logic            wr_q;
  logic [AW-1:0]   blk_q;
  logic [SW-1:0]   slot;
  logic [HALF-1:0] ev_sr, od_sr;
  logic [BITS-1:0] mem [NBLK];

  wire last = (slot == SW'(BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      wr_q  <= 1'b0;
      blk_q <= '0;
      slot  <= '0;
      ev_sr <= '0;
      od_sr <= '0;
      for (int b = 0; b < NBLK; b++) mem[b] <= '0;
    end else begin
      case (st)
        S_IDLE: if (sel_i) begin
          blk_q <= addr_i;
          wr_q  <= wr_i;
          st    <= S_LOAD;
        end
        S_LOAD: begin
          for (int i = 0; i < HALF; i++) begin
            ev_sr[i] <= mem[blk_q][2*i];
            od_sr[i] <= mem[blk_q][2*i+1];
          end
          slot <= '0;
          st   <= S_RUN;
        end
        S_RUN: begin
          if (!slot[0]) begin
            if (wr_q) ev_sr <= {sin_i, ev_sr[HALF-1:1]};
          end else begin
            od_sr <= {wr_q & sin_i, od_sr[HALF-1:1]};
            if (!wr_q) ev_sr <= {1'b0, ev_sr[HALF-1:1]};
          end
          slot <= slot + 1'b1;
          if (last) st <= wr_q ? S_COMMIT : S_IDLE;
        end
        default: begin
          for (int i = 0; i < HALF; i++) begin
            mem[blk_q][2*i]   <= ev_sr[i];
            mem[blk_q][2*i+1] <= od_sr[i];
          end
          st <= S_IDLE;
        end
      endcase
    end
  end

  assign busy_o  = (st != S_IDLE);
  assign valid_o = (st == S_RUN) && !wr_q;
  assign take_o  = (st == S_RUN) && wr_q;
  assign sout_o  = valid_o & (slot[0] ? od_sr[0] : ev_sr[0]);
endmodule

module oe_block_port_chk #(
  parameter int AW   = 5,
  parameter int BITS = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_i,
  input logic          busy_o,
  input logic          valid_o,
  input logic          take_o,
  input logic          sout_o,
  input logic [AW-1:0] blk_q
);
  localparam int CW = $clog2(BITS) + 1;
  logic [CW-1:0] vcnt, tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcnt <= '0;
      tcnt <= '0;
    end else begin
      vcnt <= valid_o ? vcnt + 1'b1 : '0;
      tcnt <= take_o  ? tcnt + 1'b1 : '0;
    end
  end

  p_start_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_o) || $rose(take_o)) |-> $past(sel_i, 2));
  p_read_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |-> (vcnt == CW'(BITS)));
  p_write_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(take_o) |-> (tcnt == CW'(BITS)));
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sel_i) |=> $stable(blk_q));
  p_quiet_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> !sout_o);
  p_one_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o || take_o) |-> busy_o);
endmodule

bind oe_block_port oe_block_port_chk #(.AW(AW), .BITS(BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .busy_o(busy_o),
  .valid_o(valid_o), .take_o(take_o), .sout_o(sout_o), .blk_q(blk_q)
);

// File: tb/oe_block_port_tb_top.sv
`timescale 1ns/1ps
module oe_block_port_tb_top;
  localparam int NBLK = 32;
  localparam int BITS = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_i = 1'b0, wr_i = 1'b0, sin_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic sout_o, valid_o, take_o, busy_o;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [BITS-1:0] exp_m [NBLK];

  always #4 clk = ~clk;

  oe_block_port #(.NBLK(NBLK), .BITS(BITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
    .sin_i(sin_i), .sout_o(sout_o), .valid_o(valid_o), .take_o(take_o),
    .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, ex);
    end
  endtask

  function automatic logic pat(int b, int k);
    return logic'((((b * 5) + (k * 3) + (k >> 3)) % 7) > 3);
  endfunction

  task automatic do_write(input int b, input logic [BITS-1:0] data);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = 5'(b);
    @(negedge clk);
    sel_i = 1'b0; wr_i = 1'b0;
    chk("R2 busy after strobe", busy_o, 1);
    chk("R2 no slot in load cycle", take_o, 0);
    @(negedge clk);
    for (int k = 0; k < BITS; k++) begin
      sin_i = data[k];
      chk("R5 take_o during slot", take_o, 1);
      @(negedge clk);
    end
    sin_i = 1'b0;
    chk("R6 commit cycle busy", {busy_o, take_o}, 2'b10);
    @(negedge clk);
    chk("R8 write busy falls", busy_o, 0);
    exp_m[b] = data;
  endtask

  task automatic do_read(input int b, input int spur_at);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = 5'(b);
    @(negedge clk);
    sel_i = 1'b0;
    chk("R2 busy after strobe", busy_o, 1);
    chk("R2 no slot in load cycle", valid_o, 0);
    @(negedge clk);
    for (int k = 0; k < BITS; k++) begin
      if (k == spur_at) begin sel_i = 1'b1; wr_i = 1'b1; addr_i = 5'(b ^ 1); end
      else begin sel_i = 1'b0; wr_i = 1'b0; end
      chk("R3 valid_o during slot", valid_o, 1);
      chk(k[0] ? "R4 odd slot bit" : "R3 even slot bit", sout_o, exp_m[b][k]);
      @(negedge clk);
    end
    sel_i = 1'b0; wr_i = 1'b0;
    chk("R8 read busy falls", busy_o, 0);
    chk("R9 pin quiet after read", {valid_o, sout_o}, 0);
  endtask

  initial begin
    for (int b = 0; b < NBLK; b++) exp_m[b] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {busy_o, valid_o, take_o, sout_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {busy_o, valid_o, take_o, sout_o}, 0);
    do_read(17, -1);
    do_read(0, -1);
    for (int b = 0; b < NBLK; b++) begin
      logic [BITS-1:0] d;
      for (int k = 0; k < BITS; k++) d[k] = (b == 3) ? ~k[0] : pat(b, k);
      do_write(b, d);
    end
    for (int b = 0; b < NBLK; b++) do_read(b, -1);
    do_read(5, 10);
    do_read(4, -1);
    do_write(31, {BITS{1'b1}});
    do_read(30, -1);
    do_read(31, -1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule